// File: doc/BRIEF.md
# Serial NOR Flash Command Interpreter

This block is the slave-side command decoder of a serial NOR flash. It watches the SPI pins (clock, active-low select, data in) with its own system clock. It gathers the one-byte command and any address or data bytes that follow it. It answers the read commands on the data-out pin. Commands that change state take effect when the select line goes high, and only if the frame ended on a byte boundary.

The block holds a small status register. That register carries a busy flag, a write-enable latch, four protection-level bits and a status-lock bit. Every command that alters that register or the array is gated by the latch, the protection level, the busy flag and a deep power-down state. Accepted program and erase commands become one-cycle request pulses with a 24-bit address, sent toward an array controller. The array controller ends the busy period with a one-cycle done pulse. The array, its timing and any wide read path lie outside this block.

Top module: `spi_flash_cmd_fe`

## Requirements
- R1: After reset the status byte reads 0x00, deep power-down is off, no request pulse is issued and `miso_oe` is 0.
- R2: Command 0x05 returns the status byte MSB first, starting with the SCK falling edge after the eighth rising edge, and repeats it while select stays low. Status layout: bit 0 busy, bit 1 write-enable latch, bits 5:2 protection level (LSB at bit 2), bit 6 always 0, bit 7 status lock.
- R3: SPI mode 0 (SCK idle low) and mode 3 (SCK idle high) give identical results. Data in is sampled on rising SCK and data out changes on falling SCK.
- R4: A byte-aligned 0x06 sets the write-enable latch and a byte-aligned 0x04 clears it.
- R5: A frame whose rising-SCK count is not a multiple of 8 has no effect on the status or on the requests.
- R6: Command 0x01 followed by a data byte, with the latch set and not busy, loads bit 7 and bits 5:2 of that byte into the status and clears the latch. Without the latch it does nothing.
- R7: While the status lock is 1 and `wp_n` is 0, command 0x01 is refused and the whole status, the latch included, is unchanged.
- R8: Page program 0x02, sector erase 0x20 and block erase 0xD8 need the latch and at least opcode plus three address bytes. Chip erase 0xC7 needs only the latch. An accepted command pulses its request for one cycle, with the address on `req_addr`, on the third clock after `cs_n` rises. It also sets busy and clears the latch. A shorter frame is refused.
- R9: Busy stays 1 until `arr_done` is sampled high. While busy, commands 0x01, 0x02, 0x20, 0xD8 and 0xC7 are ignored, but 0x06 and 0x04 still act.
- R10: A protection level n>0 guards the top min(2^(n-1), 64) 64 KiB blocks of a 4 MiB space. The block index is address bits 21:16 and bits 23:22 are ignored. A program or erase aimed at a guarded block, and chip erase at any level other than 0, is refused with no change.
- R11: Command 0xB9 enters deep power-down. In that state every command except 0xAB is ignored: no output, no status change. A byte-aligned 0xAB leaves the state.
- R12: Command 0xAB followed by three dummy bytes returns 0x15, repeated.
- R13: Command 0x90 followed by a 24-bit address returns 0xC2, 0x15 alternating when address bit 0 is 0, and 0x15, 0xC2 when it is 1. Command 0x9F returns 0xC2, 0x20, 0x16 and then 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI select, active low |
| mosi | input | 1 | SPI data from the host |
| wp_n | input | 1 | Write-protect pin, active low |
| arr_done | input | 1 | One-cycle pulse: array operation finished |
| miso | output | 1 | SPI data to the host |
| miso_oe | output | 1 | Output enable for `miso` |
| req_pp | output | 1 | Page program request pulse |
| req_se | output | 1 | Sector erase request pulse |
| req_be | output | 1 | Block erase request pulse |
| req_ce | output | 1 | Chip erase request pulse |
| req_addr | output | 24 | Address attached to the request |

## Verification
Each pin goes through a two-stage synchronizer and one edge-detect stage. A new `miso` bit is therefore registered on the third clock after an SCK fall. The bench samples it four clocks after that fall, just before it raises SCK. A request pulse is registered on the third clock after `cs_n` rises. The bench records the cycle of each pulse and checks that difference exactly. Status effects are read back afterwards through a 0x05 frame that begins at least ten clocks after the select release. The latency figures also fix the sampling points in the assertions: a request must follow a set latch in the cycle before, and busy may drop only in the cycle after `arr_done`.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;
  localparam logic [7:0] OP_REMS = 8'h90;
  localparam logic [7:0] OP_JID  = 8'h9F;

  localparam logic [7:0] ID_MFR  = 8'hC2;
  localparam logic [7:0] ID_TYPE = 8'h20;
  localparam logic [7:0] ID_CAP  = 8'h16;
  localparam logic [7:0] ID_DEV  = 8'h15;

  typedef struct packed {
    logic       lock;
    logic [3:0] lvl;
    logic       wel;
    logic       busy;
  } stat_t;

  function automatic logic [7:0] stat_byte(input stat_t s);
    return {s.lock, 1'b0, s.lvl, s.wel, s.busy};
  endfunction
endpackage

// File: rtl/sfc_pin_sync.sv
module sfc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_lvl,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic mosi_s
);
  logic [STAGES:0]   sck_q;
  logic [STAGES:0]   cs_q;
  logic [STAGES-1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[STAGES-1:0], sck};
      cs_q   <= {cs_q[STAGES-1:0], cs_n};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
    end
  end

  assign sck_lvl  = sck_q[STAGES-1];
  assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign cs_act   = ~cs_q[STAGES-1];
  assign cs_start = ~cs_q[STAGES-1] & cs_q[STAGES];
  assign cs_end   = cs_q[STAGES-1] & ~cs_q[STAGES];
  assign mosi_s   = mosi_q[STAGES-1];
endmodule

// File: rtl/sfc_frame_rx.sv
module sfc_frame_rx #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              sck_rise,
  input  logic              sck_lvl,
  input  logic              mosi_s,
  output logic [CNT_W-1:0]  bitcnt,
  output logic [7:0]        opcode,
  output logic [7:0]        byte1,
  output logic [ADDR_W-1:0] addr,
  output logic              mode3
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int SH_W = ADDR_W - 1;

  logic [SH_W-1:0]   sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [7:0]        opc_q, opc_n, b1_q, b1_n;
  logic [ADDR_W-1:0] adr_q, adr_n;
  logic              m3_q, m3_n;
  logic              en;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    opc_n = opc_q;
    b1_n  = b1_q;
    adr_n = adr_q;
    m3_n  = m3_q;
    en    = cs_start | (cs_act & sck_rise);
    if (cs_start) begin
      cnt_n = '0;
      opc_n = '0;
      m3_n  = sck_lvl;
    end else if (cs_act && sck_rise) begin
      sh_n = {sh_q[SH_W-2:0], mosi_s};
      if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(7))  opc_n = {sh_q[6:0], mosi_s};
      if (cnt_q == CNT_W'(15)) b1_n  = {sh_q[6:0], mosi_s};
      if (cnt_q == CNT_W'(8 + ADDR_W - 1)) adr_n = {sh_q, mosi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      opc_q <= '0;
      b1_q  <= '0;
      adr_q <= '0;
      m3_q  <= 1'b0;
    end else if (en) begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      opc_q <= opc_n;
      b1_q  <= b1_n;
      adr_q <= adr_n;
      m3_q  <= m3_n;
    end
  end

  assign bitcnt = cnt_q;
  assign opcode = opc_q;
  assign byte1  = b1_q;
  assign addr   = adr_q;
  assign mode3  = m3_q;
endmodule

// File: rtl/sfc_resp_tx.sv
module sfc_resp_tx
  import sfc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              mode3,
  input  logic [CNT_W-1:0]  bitcnt,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        stat,
  input  logic              dpd,
  output logic              miso,
  output logic              miso_oe
);
  localparam int NB_W = CNT_W - 3;

  logic [NB_W-1:0] nbyte, lead, k;
  logic            rd, in_out, bit_v;
  logic [7:0]      rbyte;
  logic            miso_q, miso_n, oe_q, oe_n;
  logic            unused_addr;

  assign unused_addr = ^addr[ADDR_W-1:1];
  assign nbyte = bitcnt[CNT_W-1:3];

  always_comb begin
    rd   = 1'b0;
    lead = NB_W'(1);
    case (opcode)
      OP_RDSR: rd = ~dpd;
      OP_JID:  rd = ~dpd;
      OP_RES:  begin rd = 1'b1; lead = NB_W'(4); end
      OP_REMS: begin rd = ~dpd; lead = NB_W'(4); end
      default: rd = 1'b0;
    endcase
    in_out = rd && (nbyte >= lead);
    k      = nbyte - lead;
    case (opcode)
      OP_RDSR: rbyte = stat;
      OP_RES:  rbyte = ID_DEV;
      OP_REMS: rbyte = (k[0] ^ addr[0]) ? ID_DEV : ID_MFR;
      default: begin
        if (k == NB_W'(0))      rbyte = ID_MFR;
        else if (k == NB_W'(1)) rbyte = ID_TYPE;
        else if (k == NB_W'(2)) rbyte = ID_CAP;
        else                    rbyte = 8'h00;
      end
    endcase
    bit_v = rbyte[3'd7 - bitcnt[2:0]];
  end

  always_comb begin
    miso_n = miso_q;
    oe_n   = oe_q;
    if (!cs_act) begin
      miso_n = 1'b0;
      oe_n   = 1'b0;
    end else if (sck_fall && !(mode3 && bitcnt == '0)) begin
      miso_n = in_out & bit_v;
      oe_n   = in_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      miso_q <= miso_n;
      oe_q   <= oe_n;
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int ADDR_W   = 24,
  parameter int NBLK_LOG = 6,
  parameter int BLK_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_end,
  input  logic [CNT_W-1:0]  bitcnt,
  input  logic [7:0]        opcode,
  input  logic [7:0]        byte1,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              arr_done,
  output stat_t             stat,
  output logic              dpd,
  output logic              req_pp,
  output logic              req_se,
  output logic              req_be,
  output logic              req_ce,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int NB_W = CNT_W - 3;
  localparam logic [NBLK_LOG:0] NBLK = {1'b1, {NBLK_LOG{1'b0}}};

  stat_t             st_q, st_n;
  logic              dpd_q, dpd_n, st_en;
  logic [3:0]        rq_q, rq_n;
  logic [ADDR_W-1:0] ad_q, ad_n;
  logic [NB_W-1:0]   nbytes;
  logic              aligned, wr_ok, guarded;
  logic [NBLK_LOG-1:0] blk;
  logic [NBLK_LOG:0]   nprot;
  logic              unused_b1;

  assign unused_b1 = ^{byte1[6], byte1[1:0]};
  assign nbytes  = bitcnt[CNT_W-1:3];
  assign aligned = (bitcnt[2:0] == 3'd0) && (nbytes != '0);
  assign wr_ok   = aligned && st_q.wel && !st_q.busy && !dpd_q;
  assign blk     = addr[BLK_LSB+NBLK_LOG-1:BLK_LSB];

  always_comb begin
    if (st_q.lvl == 4'd0)                      nprot = '0;
    else if (32'(st_q.lvl) > 32'(NBLK_LOG))    nprot = NBLK;
    else nprot = (NBLK_LOG+1)'(1) << (st_q.lvl - 4'd1);
    guarded = ({1'b0, blk} >= (NBLK - nprot));
  end

  always_comb begin
    st_n  = st_q;
    dpd_n = dpd_q;
    rq_n  = 4'b0000;
    ad_n  = ad_q;
    st_en = cs_end | arr_done;
    if (st_q.busy && arr_done) st_n.busy = 1'b0;
    if (cs_end && aligned) begin
      if (dpd_q) begin
        if (opcode == OP_RES) dpd_n = 1'b0;
      end else begin
        case (opcode)
          OP_WREN: st_n.wel = 1'b1;
          OP_WRDI: st_n.wel = 1'b0;
          OP_DPD:  dpd_n = 1'b1;
          OP_WRSR: begin
            if (wr_ok && nbytes >= NB_W'(2) && !(st_q.lock && !wp_n)) begin
              st_n.lock = byte1[7];
              st_n.lvl  = byte1[5:2];
              st_n.wel  = 1'b0;
            end
          end
          OP_PP, OP_SE, OP_BE: begin
            if (wr_ok && nbytes >= NB_W'(4) && !guarded) begin
              rq_n[0]   = (opcode == OP_PP);
              rq_n[1]   = (opcode == OP_SE);
              rq_n[2]   = (opcode == OP_BE);
              ad_n      = addr;
              st_n.busy = 1'b1;
              st_n.wel  = 1'b0;
            end
          end
          OP_CE: begin
            if (wr_ok && st_q.lvl == 4'd0) begin
              rq_n[3]   = 1'b1;
              ad_n      = '0;
              st_n.busy = 1'b1;
              st_n.wel  = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      dpd_q <= 1'b0;
      ad_q  <= '0;
    end else if (st_en) begin
      st_q  <= st_n;
      dpd_q <= dpd_n;
      ad_q  <= ad_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq_q <= 4'b0000;
    else        rq_q <= rq_n;
  end

  assign stat     = st_q;
  assign dpd      = dpd_q;
  assign req_pp   = rq_q[0];
  assign req_se   = rq_q[1];
  assign req_be   = rq_q[2];
  assign req_ce   = rq_q[3];
  assign req_addr = ad_q;
endmodule

// File: rtl/spi_flash_cmd_fe.sv
module spi_flash_cmd_fe
  import sfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 12,
  parameter int NBLK_LOG    = 6,
  parameter int BLK_LSB     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic        wp_n,
  input  logic        arr_done,
  output logic        miso,
  output logic        miso_oe,
  output logic        req_pp,
  output logic        req_se,
  output logic        req_be,
  output logic        req_ce,
  output logic [23:0] req_addr
);
  localparam int ADDR_W = 24;

  logic [1:0] rst_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_int = rst_q[1];

  logic sck_lvl, sck_rise, sck_fall, cs_act, cs_start, cs_end, mosi_s;
  logic [CNT_W-1:0]  bitcnt;
  logic [7:0]        opcode, byte1;
  logic [ADDR_W-1:0] addr;
  logic              mode3, dpd;
  stat_t             st;
  logic              st_wel, st_wip;

  assign st_wel = st.wel;
  assign st_wip = st.busy;

  sfc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .sck_lvl(sck_lvl), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
  );

  sfc_frame_rx #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n_int), .cs_act(cs_act), .cs_start(cs_start),
    .sck_rise(sck_rise), .sck_lvl(sck_lvl), .mosi_s(mosi_s),
    .bitcnt(bitcnt), .opcode(opcode), .byte1(byte1), .addr(addr), .mode3(mode3)
  );

  sfc_resp_tx #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tx (
    .clk(clk), .rst_n(rst_n_int), .cs_act(cs_act), .sck_fall(sck_fall),
    .mode3(mode3), .bitcnt(bitcnt), .opcode(opcode), .addr(addr),
    .stat(stat_byte(st)), .dpd(dpd), .miso(miso), .miso_oe(miso_oe)
  );

  sfc_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NBLK_LOG(NBLK_LOG), .BLK_LSB(BLK_LSB)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .cs_end(cs_end), .bitcnt(bitcnt),
    .opcode(opcode), .byte1(byte1), .addr(addr), .wp_n(wp_n), .arr_done(arr_done),
    .stat(st), .dpd(dpd), .req_pp(req_pp), .req_se(req_se), .req_be(req_be),
    .req_ce(req_ce), .req_addr(req_addr)
  );
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_pp,
  input logic req_se,
  input logic req_be,
  input logic req_ce,
  input logic wel,
  input logic wip,
  input logic dpd,
  input logic arr_done,
  input logic miso,
  input logic miso_oe
);
  logic req_any;
  assign req_any = req_pp | req_se | req_be | req_ce;

  // R8: at most one request kind per cycle
  a_r8_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_pp, req_se, req_be, req_ce}));

  // R8: a request needs the latch set one cycle earlier, and clears it
  a_r8_req_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> ($past(wel) && !wel));

  // R9: busy is set together with the request
  a_r9_req_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> wip);

  // R9: busy only falls after a done pulse
  a_r9_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> $past(arr_done));

  // R11: no request while in deep power-down
  a_r11_no_req_in_dpd: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> !dpd);

  // R2: data-out stays low while not enabled
  a_r2_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);
endmodule

bind spi_flash_cmd_fe sfc_chk u_chk (
  .clk(clk), .rst_n(rst_n_int), .req_pp(req_pp), .req_se(req_se),
  .req_be(req_be), .req_ce(req_ce), .wel(st_wel), .wip(st_wip), .dpd(dpd),
  .arr_done(arr_done), .miso(miso), .miso_oe(miso_oe)
);

// File: tb/sim_spi_flash_cmd_fe.sv
module sim_spi_flash_cmd_fe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1, arr_done = 1'b0;
  logic miso, miso_oe, req_pp, req_se, req_be, req_ce;
  logic [23:0] req_addr;

  spi_flash_cmd_fe u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n),
    .arr_done(arr_done), .miso(miso), .miso_oe(miso_oe), .req_pp(req_pp),
    .req_se(req_se), .req_be(req_be), .req_ce(req_ce), .req_addr(req_addr)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, raise_cyc = 0, req_cyc = 0;
  int pp_n = 0, se_n = 0, be_n = 0, ce_n = 0;
  logic [23:0] last_addr = '0;
  bit oe_seen = 1'b0, fin = 1'b0;
  logic [7:0] s, r0, r1, r2, r3;
  int b_pp, b_se, b_be, b_ce;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (req_pp) begin pp_n++; last_addr = req_addr; req_cyc = cyc; end
    if (req_se) begin se_n++; last_addr = req_addr; req_cyc = cyc; end
    if (req_be) begin be_n++; last_addr = req_addr; req_cyc = cyc; end
    if (req_ce) begin ce_n++; last_addr = req_addr; req_cyc = cyc; end
  end

  // {opcode, data byte, expected status}
  localparam logic [23:0] TBL [11] = '{
    {8'h06, 8'h00, 8'h02}, {8'h04, 8'h00, 8'h00}, {8'h01, 8'h3C, 8'h00},
    {8'h06, 8'h00, 8'h02}, {8'h01, 8'h0C, 8'h0C}, {8'h06, 8'h00, 8'h0E},
    {8'h01, 8'hFF, 8'hBC}, {8'h06, 8'h00, 8'hBE}, {8'h01, 8'h00, 8'h00},
    {8'h06, 8'h00, 8'h02}, {8'h04, 8'h00, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cs_begin(input bit m3);
    sck = m3;
    tick(4);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    tick(4);
  endtask

  task automatic bit_x(input bit b, output bit r);
    sck = 1'b0;
    mosi = b;
    tick(4);
    r = miso;
    if (miso_oe) oe_seen = 1'b1;
    sck = 1'b1;
    tick(4);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      bit rb;
      bit_x(tx[i], rb);
      rx[i] = rb;
    end
  endtask

  task automatic cs_finish(input bit m3);
    if (!m3) sck = 1'b0;
    tick(4);
    cs_n = 1'b1;
    raise_cyc = cyc;
    tick(10);
  endtask

  task automatic op_only(input logic [7:0] op, input bit m3);
    logic [7:0] d;
    cs_begin(m3); byte_x(op, d); cs_finish(m3);
  endtask

  task automatic wrsr(input logic [7:0] v, input bit m3);
    logic [7:0] d;
    cs_begin(m3); byte_x(8'h01, d); byte_x(v, d); cs_finish(m3);
  endtask

  task automatic op_addr(input logic [7:0] op, input logic [23:0] a, input int nd, input bit m3);
    logic [7:0] d;
    cs_begin(m3);
    byte_x(op, d); byte_x(a[23:16], d); byte_x(a[15:8], d); byte_x(a[7:0], d);
    for (int i = 0; i < nd; i++) byte_x(8'hA5, d);
    cs_finish(m3);
  endtask

  task automatic rd_status(input bit m3, output logic [7:0] v);
    logic [7:0] d;
    cs_begin(m3); byte_x(8'h05, d); byte_x(8'h00, v); cs_finish(m3);
  endtask

  task automatic done_pulse();
    arr_done = 1'b1; tick(1); arr_done = 1'b0; tick(2);
  endtask

  task automatic snap();
    b_pp = pp_n; b_se = se_n; b_be = be_n; b_ce = ce_n;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    chk("R1 miso_oe after reset", 32'(miso_oe), 0);
    rd_status(1'b0, s);
    chk("R1 status after reset", 32'(s), 32'h00);
    chk("R1 no requests", pp_n + se_n + be_n + ce_n, 0);

    // table: status commands, alternating modes (R3)
    for (int i = 0; i < 11; i++) begin
      bit m3 = bit'(i % 2);
      if (TBL[i][23:16] == 8'h01) wrsr(TBL[i][15:8], m3);
      else op_only(TBL[i][23:16], m3);
      rd_status(m3, s);
      chk($sformatf("R4 R6 R3 table entry %0d", i), 32'(s), 32'(TBL[i][7:0]));
    end

    // R2 status repeats
    op_only(8'h06, 1'b0);
    cs_begin(1'b0); byte_x(8'h05, r0); byte_x(8'h00, r1); byte_x(8'h00, r2); cs_finish(1'b0);
    chk("R2 status first byte", 32'(r1), 32'h02);
    chk("R2 status repeated", 32'(r2), 32'h02);
    op_only(8'h04, 1'b0);

    // R5 unaligned frames
    cs_begin(1'b0);
    for (int i = 7; i >= 1; i--) begin bit rb; bit_x(i == 1 || i == 2, rb); end
    cs_finish(1'b0);
    rd_status(1'b0, s);
    chk("R5 seven-bit WREN ignored", 32'(s), 32'h00);
    cs_begin(1'b1); byte_x(8'h06, r0);
    for (int i = 0; i < 4; i++) begin bit rb; bit_x(1'b0, rb); end
    cs_finish(1'b1);
    rd_status(1'b1, s);
    chk("R5 twelve-bit WREN ignored", 32'(s), 32'h00);

    // R7 status lock with wp_n low
    op_only(8'h06, 1'b0); wrsr(8'h80, 1'b0);
    wp_n = 1'b0;
    op_only(8'h06, 1'b0); wrsr(8'h3C, 1'b0);
    rd_status(1'b0, s);
    chk("R7 locked WRSR refused", 32'(s), 32'h82);
    wp_n = 1'b1;
    wrsr(8'h00, 1'b0);
    rd_status(1'b0, s);
    chk("R7 unlocked with wp_n high", 32'(s), 32'h00);

    // R8 sector erase with exact latency
    op_only(8'h06, 1'b0); snap();
    op_addr(8'h20, 24'h012345, 0, 1'b0);
    chk("R8 sector erase request", se_n - b_se, 1);
    chk("R8 sector erase address", 32'(last_addr), 32'h012345);
    chk("R8 request latency", req_cyc - raise_cyc, 3);
    rd_status(1'b0, s);
    chk("R8 busy set latch cleared", 32'(s), 32'h01);

    // R9 busy gating
    op_only(8'h06, 1'b1);
    rd_status(1'b1, s);
    chk("R9 WREN acts while busy", 32'(s), 32'h03);
    snap(); op_addr(8'h20, 24'h020000, 0, 1'b1);
    chk("R9 erase ignored while busy", se_n - b_se, 0);
    done_pulse();
    rd_status(1'b0, s);
    chk("R9 done clears busy", 32'(s), 32'h02);

    // R8 block erase, page program, short frame, chip erase
    snap(); op_addr(8'hD8, 24'h100000, 0, 1'b0);
    chk("R8 block erase request", be_n - b_be, 1);
    chk("R8 block erase address", 32'(last_addr), 32'h100000);
    done_pulse();
    op_only(8'h06, 1'b0); snap(); op_addr(8'h02, 24'h000100, 2, 1'b1);
    chk("R8 page program request", pp_n - b_pp, 1);
    chk("R8 page program address", 32'(last_addr), 32'h000100);
    done_pulse();
    op_only(8'h06, 1'b0); snap();
    cs_begin(1'b0); byte_x(8'h02, r0); byte_x(8'h00, r0); byte_x(8'h01, r0); cs_finish(1'b0);
    chk("R8 short program refused", pp_n - b_pp, 0);
    rd_status(1'b0, s);
    chk("R8 short program no effect", 32'(s), 32'h02);
    snap(); op_only(8'hC7, 1'b0);
    chk("R8 chip erase request", ce_n - b_ce, 1);
    done_pulse();
    rd_status(1'b0, s);
    chk("R8 chip erase cleared", 32'(s), 32'h00);

    // R10 protection
    op_only(8'h06, 1'b0); wrsr(8'h04, 1'b0);
    op_only(8'h06, 1'b0); snap();
    op_addr(8'h20, 24'h3F0000, 0, 1'b0);
    op_addr(8'h20, 24'hFF0000, 0, 1'b0);
    chk("R10 top block guarded", se_n - b_se, 0);
    rd_status(1'b0, s);
    chk("R10 refused leaves status", 32'(s), 32'h06);
    op_addr(8'h20, 24'h3E0000, 0, 1'b0);
    chk("R10 lower block open", se_n - b_se, 1);
    done_pulse();
    op_only(8'h06, 1'b0); snap(); op_only(8'hC7, 1'b0);
    chk("R10 chip erase refused", ce_n - b_ce, 0);
    wrsr(8'h1C, 1'b0);
    op_only(8'h06, 1'b0); snap(); op_addr(8'h20, 24'h000000, 0, 1'b0);
    chk("R10 full guard", se_n - b_se, 0);
    wrsr(8'h00, 1'b0);
    rd_status(1'b0, s);
    chk("R10 guard removed", 32'(s), 32'h00);

    // R11 deep power-down
    op_only(8'hB9, 1'b0);
    rd_status(1'b0, s);
    chk("R11 status read silent", 32'(oe_seen), 0);
    cs_begin(1'b1); byte_x(8'h9F, r0); byte_x(8'h00, r1); cs_finish(1'b1);
    chk("R11 id read silent", 32'(oe_seen), 0);
    op_only(8'h06, 1'b0);
    cs_begin(1'b0);
    byte_x(8'hAB, r0); byte_x(8'h00, r0); byte_x(8'h00, r0); byte_x(8'h00, r0); byte_x(8'h00, r1);
    cs_finish(1'b0);
    chk("R11 R12 signature in power-down", 32'(r1), 32'h15);
    rd_status(1'b0, s);
    chk("R11 released and WREN was ignored", 32'(s), 32'h00);
    chk("R11 output enabled again", 32'(oe_seen), 1);

    // R12 signature
    cs_begin(1'b1);
    byte_x(8'hAB, r0); byte_x(8'h00, r0); byte_x(8'h00, r0); byte_x(8'h00, r0);
    byte_x(8'h00, r1); byte_x(8'h00, r2);
    cs_finish(1'b1);
    chk("R12 signature byte", 32'(r1), 32'h15);
    chk("R12 signature repeats", 32'(r2), 32'h15);

    // R13 identification
    cs_begin(1'b0);
    byte_x(8'h90, r0); byte_x(8'h00, r0); byte_x(8'h00, r0); byte_x(8'h00, r0);
    byte_x(8'h00, r1); byte_x(8'h00, r2);
    cs_finish(1'b0);
    chk("R13 ids at address 0", {16'h0, r1, r2}, 32'hC215);
    cs_begin(1'b0);
    byte_x(8'h90, r0); byte_x(8'h00, r0); byte_x(8'h00, r0); byte_x(8'h01, r0);
    byte_x(8'h00, r1); byte_x(8'h00, r2);
    cs_finish(1'b0);
    chk("R13 ids at address 1", {16'h0, r1, r2}, 32'h15C2);
    for (int m = 0; m < 2; m++) begin
      cs_begin(bit'(m));
      byte_x(8'h9F, r0); byte_x(8'h00, r0); byte_x(8'h00, r1); byte_x(8'h00, r2); byte_x(8'h00, r3);
      cs_finish(bit'(m));
      chk($sformatf("R13 R3 three-byte id mode %0d", m*3), {r0, r1, r2, r3}, 32'hC2201600);
    end

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule